// File: doc/BRIEF.md
# TPM FIFO Command/Response Sequencer

This block runs one full command/response exchange with a TPM-style device through its status and data FIFO registers. A caller supplies a command length and a response size limit and pulses a start input. The block first reads the size field embedded in the command and compares it with the supplied length. It then issues, in a fixed order, the register transactions that make up the exchange. Each transaction goes to a neighbouring transaction engine, which handles SPI framing, flow control and burst-count chunking. Command bytes are fetched by that engine straight from the caller's buffer at the offset the block names.

Response bytes that the neighbour returns from FIFO reads are forwarded to the caller one cycle later, in arrival order. The response is read in three parts: the 6-byte header, then every byte but the last, then the last byte alone. The status flags are checked after the second and third parts, which confirms that the device reports data-available up to the final byte and drops it afterwards. The exchange ends with a completion pulse carrying an error code and the response size.

Top module: `tpm_xchg_seq`

## Requirements
- R1: After start, command bytes 2..5 (big-endian, fetched through `cmd_addr_o`/`cmd_data_i`) must equal `cmd_len_i`. Otherwise the exchange completes with error code 1 and no transaction is requested.
- R2: The exchange opens with three requests in order. Op codes are 0 status write, 1 status read, 2 FIFO write and 3 FIFO read. The three requests are: a status write of 0x40 (command-ready, bit 6), a FIFO write of `cmd_len_i` bytes at offset 0, and a status write of 0x20 (go, bit 5).
- R3: After go, status reads are repeated until `txn_flags_i` shows both status-valid (bit 1) and data-available (bit 0).
- R4: If a poll result is not ready and at least `TIMEOUT_CYC` cycles have been spent polling, the exchange completes with error code 2 and no FIFO read is requested.
- R5: A FIFO read of 6 bytes at offset 0 fetches the header, whose bytes 2..5 are the big-endian response size. A size above `max_rsp_i` gives error code 3. A size below 7 gives error code 6.
- R6: Next comes a FIFO read of size-7 bytes at offset 6, which is skipped when that count is zero. A status read follows, and it must show both flags set; otherwise error code 4.
- R7: Next comes a FIFO read of 1 byte at offset size-1. A status read follows, and it must show status-valid set and data-available clear; otherwise error code 5.
- R8: On success a final status write of 0x40 is issued. Completion then reports error code 0 and `rsp_len_o` equal to the response size. Any error completion reports `rsp_len_o` = 0, and no further request is made after an error.
- R9: Every byte received on `rx_valid_i`/`rx_byte_i` during a FIFO read appears on `rsp_valid_o`/`rsp_byte_o` one cycle later, in order.
- R10: `done_o` is a one-cycle pulse. `busy_o` is high from the cycle after an accepted start until the cycle after `done_o`. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exchange (sampled when idle) |
| cmd_len_i | input | 32 | Command length in bytes |
| max_rsp_i | input | 32 | Largest response size accepted |
| cmd_addr_o | output | 3 | Command byte offset being checked |
| cmd_data_i | input | 8 | Command byte at `cmd_addr_o` (combinational) |
| txn_valid_o | output | 1 | Transaction request present |
| txn_op_o | output | 2 | Request op code |
| txn_len_o | output | 32 | FIFO byte count |
| txn_off_o | output | 32 | Buffer offset for FIFO request |
| txn_wdata_o | output | 32 | Status word for status write |
| txn_done_i | input | 1 | Current request finished (one cycle) |
| txn_flags_i | input | 2 | Status read result: bit 1 status-valid, bit 0 data-available |
| rx_valid_i | input | 1 | Response byte from FIFO read |
| rx_byte_i | input | 8 | Response byte value |
| rsp_valid_o | output | 1 | Forwarded response byte valid |
| rsp_byte_o | output | 8 | Forwarded response byte |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | Exchange complete pulse |
| err_o | output | 3 | Completion code |
| rsp_len_o | output | 32 | Response size on success |

## Verification
A sequencer stuck in or skipping a phase shows up at the transaction port. The bench sees a missing, reordered or mis-sized request within the request that follows the fault, well before completion. A wrongly captured size field shows up as a wrong body length or offset on the very next FIFO read, or as a false size error. A flag check inverted at the intermediate or final status read changes the error code reported on `done_o` a few cycles later, and forwarding faults change the stream of response bytes byte for byte.

// File: rtl/tpm_xchg_pkg.sv
package tpm_xchg_pkg;
  localparam int SIZE_W    = 32;
  localparam int HDR_BYTES = 6;
  localparam int RDY_BIT   = 6;
  localparam int GO_BIT    = 5;

  typedef enum logic [1:0] {
    OP_STS_WR  = 2'd0,
    OP_STS_RD  = 2'd1,
    OP_FIFO_WR = 2'd2,
    OP_FIFO_RD = 2'd3
  } txn_op_e;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_CMD_SIZE  = 3'd1;
  localparam logic [2:0] ERR_TIMEOUT   = 3'd2;
  localparam logic [2:0] ERR_RSP_BIG   = 3'd3;
  localparam logic [2:0] ERR_MID_STS   = 3'd4;
  localparam logic [2:0] ERR_FIN_STS   = 3'd5;
  localparam logic [2:0] ERR_RSP_SHORT = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_CMP, S_WR_RDY, S_WR_FIFO, S_WR_GO, S_POLL, S_HDR,
    S_HDR_CHK, S_BODY, S_MID, S_LAST, S_FIN, S_IDLE_WR, S_DONE
  } seq_state_e;
endpackage

// File: rtl/tpm_be_field_cap.sv
module tpm_be_field_cap #(
  parameter int IDX_W = 3,
  parameter int FIRST = 2,
  parameter int NB    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [8*NB-1:0]  val_o
);
  localparam logic [IDX_W-1:0] LO = IDX_W'(FIRST);
  localparam logic [IDX_W-1:0] HI = IDX_W'(FIRST + NB - 1);

  logic in_win;
  assign in_win = (idx_i >= LO) && (idx_i <= HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 val_o <= '0;
    else if (clr_i)              val_o <= '0;
    else if (en_i && in_win)     val_o <= {val_o[8*NB-9:0], byte_i};
  end
endmodule

// File: rtl/tpm_poll_timer.sv
module tpm_poll_timer #(
  parameter int               W     = 32,
  parameter logic [W-1:0]     LIMIT = W'(1000)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (en_i && cnt_q < LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= LIMIT);

  assert_timer_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/tpm_rx_fwd.sv
module tpm_rx_fwd (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       fwd_en_i,
  input  logic       cnt_en_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_byte_o,
  output logic [2:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_byte_o  <= '0;
    end else begin
      rsp_valid_o <= rx_valid_i && fwd_en_i;
      if (rx_valid_i && fwd_en_i) rsp_byte_o <= rx_byte_i;
    end
  end

  // header byte index, saturates past the header
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       cnt_o <= '0;
    else if (clr_i)                                    cnt_o <= '0;
    else if (rx_valid_i && cnt_en_i && cnt_o != 3'd7)  cnt_o <= cnt_o + 3'd1;
  end

  assert_fwd_follows_rx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(rx_valid_i));
endmodule

// File: rtl/tpm_xchg_seq.sv
module tpm_xchg_seq
  import tpm_xchg_pkg::*;
#(
  parameter int                 TIMER_W     = 32,
  parameter logic [TIMER_W-1:0] TIMEOUT_CYC = TIMER_W'(120_000_000)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] cmd_len_i,
  input  logic [SIZE_W-1:0] max_rsp_i,
  output logic [2:0]        cmd_addr_o,
  input  logic [7:0]        cmd_data_i,
  output logic              txn_valid_o,
  output logic [1:0]        txn_op_o,
  output logic [SIZE_W-1:0] txn_len_o,
  output logic [SIZE_W-1:0] txn_off_o,
  output logic [31:0]       txn_wdata_o,
  input  logic              txn_done_i,
  input  logic [1:0]        txn_flags_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_byte_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        err_o,
  output logic [SIZE_W-1:0] rsp_len_o
);
  localparam logic [31:0]       RDY_WORD = 32'd1 << RDY_BIT;
  localparam logic [31:0]       GO_WORD  = 32'd1 << GO_BIT;
  localparam logic [SIZE_W-1:0] HDR_LEN  = SIZE_W'(HDR_BYTES);
  localparam logic [SIZE_W-1:0] MIN_RSP  = SIZE_W'(HDR_BYTES + 1);

  seq_state_e        state_q, nxt;
  logic [2:0]        err_q, err_nxt;
  logic [SIZE_W-1:0] cmd_len_q, max_q, rsp_len_q;
  logic [2:0]        chk_idx_q;
  logic              size_ok_q;
  logic              accept;

  logic [SIZE_W-1:0] cmd_size, rsp_size;
  logic [2:0]        hdr_idx;
  logic              tmo_exp;
  logic              flags_ready, flags_last;

  txn_op_e           op_c;
  logic              valid_c;
  logic [SIZE_W-1:0] len_c, off_c;
  logic [31:0]       wd_c;

  assign accept      = (state_q == S_IDLE) && start_i;
  assign flags_ready = txn_flags_i[1] & txn_flags_i[0];
  assign flags_last  = txn_flags_i[1] & ~txn_flags_i[0];

  tpm_be_field_cap #(.IDX_W(3), .FIRST(2), .NB(4)) u_cmd_size (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (state_q == S_CHK),
    .idx_i  (chk_idx_q),
    .byte_i (cmd_data_i),
    .val_o  (cmd_size)
  );

  tpm_rx_fwd u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .fwd_en_i    (state_q == S_HDR || state_q == S_BODY || state_q == S_LAST),
    .cnt_en_i    (state_q == S_HDR),
    .rx_valid_i  (rx_valid_i),
    .rx_byte_i   (rx_byte_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_byte_o  (rsp_byte_o),
    .cnt_o       (hdr_idx)
  );

  tpm_be_field_cap #(.IDX_W(3), .FIRST(2), .NB(4)) u_rsp_size (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (rx_valid_i && state_q == S_HDR),
    .idx_i  (hdr_idx),
    .byte_i (rx_byte_i),
    .val_o  (rsp_size)
  );

  tpm_poll_timer #(.W(TIMER_W), .LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == S_WR_GO && txn_done_i),
    .en_i      (state_q == S_POLL),
    .expired_o (tmo_exp)
  );

  always_comb begin
    nxt     = state_q;
    err_nxt = err_q;
    valid_c = 1'b0;
    op_c    = OP_STS_WR;
    len_c   = '0;
    off_c   = '0;
    wd_c    = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        nxt     = S_CHK;
        err_nxt = ERR_NONE;
      end
      S_CHK: if (chk_idx_q == 3'd5) nxt = S_CMP;
      S_CMP: begin
        if (cmd_size == cmd_len_q) nxt = S_WR_RDY;
        else begin nxt = S_DONE; err_nxt = ERR_CMD_SIZE; end
      end
      S_WR_RDY: begin
        valid_c = 1'b1; op_c = OP_STS_WR; wd_c = RDY_WORD;
        if (txn_done_i) nxt = S_WR_FIFO;
      end
      S_WR_FIFO: begin
        valid_c = 1'b1; op_c = OP_FIFO_WR; len_c = cmd_len_q;
        if (txn_done_i) nxt = S_WR_GO;
      end
      S_WR_GO: begin
        valid_c = 1'b1; op_c = OP_STS_WR; wd_c = GO_WORD;
        if (txn_done_i) nxt = S_POLL;
      end
      S_POLL: begin
        valid_c = 1'b1; op_c = OP_STS_RD;
        if (txn_done_i) begin
          if (flags_ready) nxt = S_HDR;
          else if (tmo_exp) begin nxt = S_DONE; err_nxt = ERR_TIMEOUT; end
        end
      end
      S_HDR: begin
        valid_c = 1'b1; op_c = OP_FIFO_RD; len_c = HDR_LEN;
        if (txn_done_i) nxt = S_HDR_CHK;
      end
      S_HDR_CHK: begin
        if (rsp_size > max_q)         begin nxt = S_DONE; err_nxt = ERR_RSP_BIG; end
        else if (rsp_size < MIN_RSP)  begin nxt = S_DONE; err_nxt = ERR_RSP_SHORT; end
        else if (rsp_size == MIN_RSP) nxt = S_MID;
        else                          nxt = S_BODY;
      end
      S_BODY: begin
        valid_c = 1'b1; op_c = OP_FIFO_RD;
        len_c = rsp_size - MIN_RSP; off_c = HDR_LEN;
        if (txn_done_i) nxt = S_MID;
      end
      S_MID: begin
        valid_c = 1'b1; op_c = OP_STS_RD;
        if (txn_done_i) begin
          if (flags_ready) nxt = S_LAST;
          else begin nxt = S_DONE; err_nxt = ERR_MID_STS; end
        end
      end
      S_LAST: begin
        valid_c = 1'b1; op_c = OP_FIFO_RD;
        len_c = SIZE_W'(1); off_c = rsp_size - SIZE_W'(1);
        if (txn_done_i) nxt = S_FIN;
      end
      S_FIN: begin
        valid_c = 1'b1; op_c = OP_STS_RD;
        if (txn_done_i) begin
          if (flags_last) nxt = S_IDLE_WR;
          else begin nxt = S_DONE; err_nxt = ERR_FIN_STS; end
        end
      end
      S_IDLE_WR: begin
        valid_c = 1'b1; op_c = OP_STS_WR; wd_c = RDY_WORD;
        if (txn_done_i) nxt = S_DONE;
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      err_q     <= ERR_NONE;
      cmd_len_q <= '0;
      max_q     <= '0;
      rsp_len_q <= '0;
      chk_idx_q <= 3'd2;
      size_ok_q <= 1'b0;
    end else begin
      state_q <= nxt;
      err_q   <= err_nxt;
      if (accept) begin
        cmd_len_q <= cmd_len_i;
        max_q     <= max_rsp_i;
        chk_idx_q <= 3'd2;
        size_ok_q <= 1'b0;
      end else if (state_q == S_CHK) begin
        chk_idx_q <= chk_idx_q + 3'd1;
      end
      if (state_q == S_CMP && cmd_size == cmd_len_q) size_ok_q <= 1'b1;
      if (nxt == S_DONE && state_q != S_DONE)
        rsp_len_q <= (err_nxt == ERR_NONE) ? rsp_size : '0;
    end
  end

  assign cmd_addr_o  = chk_idx_q;
  assign txn_valid_o = valid_c;
  assign txn_op_o    = op_c;
  assign txn_len_o   = len_c;
  assign txn_off_o   = off_c;
  assign txn_wdata_o = wd_c;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign err_o       = err_q;
  assign rsp_len_o   = rsp_len_q;

  assert_no_txn_before_size_ok_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txn_valid_o) |-> size_ok_q);

  assert_timeout_needs_expiry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_TIMEOUT) |-> $past(tmo_exp));

  assert_ok_len_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_NONE) |-> (rsp_len_o >= MIN_RSP));

  assert_txn_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> busy_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/tpm_xchg_seq_test.sv
module tpm_xchg_seq_test;
  import tpm_xchg_pkg::*;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic        rst_ni, start_i;
  logic [31:0] cmd_len_i, max_rsp_i;
  logic [2:0]  cmd_addr_o;
  logic [7:0]  cmd_data_i;
  logic        txn_valid_o;
  logic [1:0]  txn_op_o;
  logic [31:0] txn_len_o, txn_off_o, txn_wdata_o;
  logic        txn_done_i;
  logic [1:0]  txn_flags_i;
  logic        rx_valid_i;
  logic [7:0]  rx_byte_i;
  logic        rsp_valid_o;
  logic [7:0]  rsp_byte_o;
  logic        busy_o, done_o;
  logic [2:0]  err_o;
  logic [31:0] rsp_len_o;

  logic [7:0] cmd_mem [0:7];
  assign cmd_data_i = cmd_mem[cmd_addr_o];

  tpm_xchg_seq #(.TIMER_W(32), .TIMEOUT_CYC(32'd40)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_len_i(cmd_len_i),
    .max_rsp_i(max_rsp_i), .cmd_addr_o(cmd_addr_o), .cmd_data_i(cmd_data_i),
    .txn_valid_o(txn_valid_o), .txn_op_o(txn_op_o), .txn_len_o(txn_len_o),
    .txn_off_o(txn_off_o), .txn_wdata_o(txn_wdata_o), .txn_done_i(txn_done_i),
    .txn_flags_i(txn_flags_i), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
    .rsp_valid_o(rsp_valid_o), .rsp_byte_o(rsp_byte_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .rsp_len_o(rsp_len_o)
  );

  int checks = 0, fails = 0;
  logic [97:0] req_q[$];
  logic [7:0]  rsp_q[$];
  int hdr_size, poll_nr, poll_ct, last_end;
  logic [1:0] mid_flags, fin_flags;
  bit fifo_seen, prev_done;

  function automatic logic [97:0] mk(logic [1:0] op, int len, int off, logic [31:0] wd);
    return {op, 32'(len), 32'(off), wd};
  endfunction

  function automatic logic [7:0] rbyte(int k);
    if (k == 0) return 8'h80;
    if (k == 1) return 8'h01;
    if (k >= 2 && k <= 5) return 8'((hdr_size >> (8 * (5 - k))) & 255);
    return 8'((k * 13 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  // neighbour transaction engine model
  initial begin
    txn_done_i = 1'b0; txn_flags_i = 2'b00; rx_valid_i = 1'b0; rx_byte_i = '0;
    forever begin
      @(negedge clk_i);
      txn_done_i = 1'b0;
      if (rst_ni && txn_valid_o) begin
        logic [1:0] op; int len, off;
        op = txn_op_o; len = int'(txn_len_o); off = int'(txn_off_o);
        req_q.push_back({txn_op_o, txn_len_o, txn_off_o, txn_wdata_o});
        repeat (2) @(negedge clk_i);
        if (op == OP_FIFO_RD) begin
          for (int i = 0; i < len; i++) begin
            rx_valid_i = 1'b1; rx_byte_i = rbyte(off + i);
            @(negedge clk_i);
          end
          rx_valid_i = 1'b0;
          fifo_seen = 1'b1; last_end = off + len;
        end
        if (op == OP_STS_RD) begin
          if (!fifo_seen) begin
            txn_flags_i = (poll_ct < poll_nr) ? 2'b10 : 2'b11;
            poll_ct++;
          end else if (last_end == hdr_size) txn_flags_i = fin_flags;
          else txn_flags_i = mid_flags;
        end
        txn_done_i = 1'b1;
      end
    end
  end

  // per-clock monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rsp_valid_o) rsp_q.push_back(rsp_byte_o);
      chk(!(txn_valid_o && !busy_o), "R10", "request while idle", txn_valid_o, 0);
      chk(!(done_o && prev_done), "R10", "done wider than 1", 2, 1);
      prev_done = done_o;
    end
  end

  task automatic run_case(input string rq, input int clen, input int enc, input int hsz,
                          input int mx, input int pnr, input logic [1:0] mf,
                          input logic [1:0] ff, input int exp_err, input bit poke);
    logic [97:0] exp_q[$];
    int n, nrsp, exp_len;
    bit ok;
    cmd_mem[0] = 8'h80; cmd_mem[1] = 8'h01;
    for (int i = 2; i < 6; i++) cmd_mem[i] = 8'((enc >> (8 * (5 - i))) & 255);
    cmd_mem[6] = 8'h11; cmd_mem[7] = 8'h22;
    hdr_size = hsz; poll_nr = pnr; poll_ct = 0; fifo_seen = 0; last_end = 0;
    mid_flags = mf; fin_flags = ff;
    req_q.delete(); rsp_q.delete();
    cmd_len_i = 32'(clen); max_rsp_i = 32'(mx); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o, rq, "busy after start", busy_o, 1);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      cmd_len_i = 32'(clen + 3); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    chk(done_o, rq, "done seen", done_o, 1);
    chk(err_o == 3'(exp_err), rq, "err code", err_o, exp_err);
    exp_len = (exp_err == 0) ? hsz : 0;
    chk(rsp_len_o == 32'(exp_len), rq, "rsp_len", rsp_len_o, exp_len);
    // expected request sequence
    if (exp_err != 1) begin
      exp_q.push_back(mk(OP_STS_WR, 0, 0, 32'h40));
      exp_q.push_back(mk(OP_FIFO_WR, clen, 0, 0));
      exp_q.push_back(mk(OP_STS_WR, 0, 0, 32'h20));
      if (exp_err != 2) begin
        for (int i = 0; i <= pnr; i++) exp_q.push_back(mk(OP_STS_RD, 0, 0, 0));
        exp_q.push_back(mk(OP_FIFO_RD, 6, 0, 0));
        if (exp_err != 3 && exp_err != 6) begin
          if (hsz > 7) exp_q.push_back(mk(OP_FIFO_RD, hsz - 7, 6, 0));
          exp_q.push_back(mk(OP_STS_RD, 0, 0, 0));
          if (exp_err != 4) begin
            exp_q.push_back(mk(OP_FIFO_RD, 1, hsz - 1, 0));
            exp_q.push_back(mk(OP_STS_RD, 0, 0, 0));
            if (exp_err != 5) exp_q.push_back(mk(OP_STS_WR, 0, 0, 32'h40));
          end
        end
      end
    end
    if (exp_err == 2) begin
      ok = (req_q.size() >= 5);
      for (int i = 0; i < req_q.size(); i++)
        if (i < 3) ok = ok && (req_q[i] == exp_q[i]);
        else ok = ok && (req_q[i] == mk(OP_STS_RD, 0, 0, 0));
      chk(ok, "R4", "timeout: only polls after go", req_q.size(), 5);
    end else begin
      ok = (req_q.size() == exp_q.size());
      for (int i = 0; i < exp_q.size() && ok; i++) ok = (req_q[i] == exp_q[i]);
      chk(ok, rq, "request sequence (count)", req_q.size(), exp_q.size());
    end
    case (exp_err)
      0, 5:    nrsp = hsz;
      3, 6:    nrsp = 6;
      4:       nrsp = hsz - 1;
      default: nrsp = 0;
    endcase
    ok = (rsp_q.size() == nrsp);
    for (int i = 0; i < nrsp && ok; i++) ok = (rsp_q[i] == rbyte(i));
    chk(ok, "R9", "forwarded bytes (count)", rsp_q.size(), nrsp);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R10", "idle after done", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; cmd_len_i = '0; max_rsp_i = '0; prev_done = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !txn_valid_o && !rsp_valid_o, "R10", "reset state",
        {busy_o, done_o, txn_valid_o, rsp_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_case("R2 R3 R8 R10", 10, 10, 12, 64, 2, 2'b11, 2'b10, 0, 1'b1);
    run_case("R1", 10, 11, 12, 64, 0, 2'b11, 2'b10, 1, 1'b0);
    run_case("R4", 9, 9, 12, 64, 1000000, 2'b11, 2'b10, 2, 1'b0);
    run_case("R5 oversize", 8, 8, 30, 20, 0, 2'b11, 2'b10, 3, 1'b0);
    run_case("R5 short", 8, 8, 6, 64, 1, 2'b11, 2'b10, 6, 1'b0);
    run_case("R6", 12, 12, 15, 64, 0, 2'b10, 2'b10, 4, 1'b0);
    run_case("R7", 12, 12, 15, 64, 1, 2'b11, 2'b11, 5, 1'b0);
    run_case("R6 R7 R8 size7", 6, 6, 7, 7, 0, 2'b11, 2'b10, 0, 1'b0);
    run_case("R6 R8 size8", 7, 7, 8, 8, 3, 2'b11, 2'b10, 0, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule